// File: doc/BRIEF.md
# Timestamped Scheduled Output Port

This block drives one output pin. The pin changes only when a write takes effect, and a write can be placed on an exact count of a free-running port counter. The counter steps once on every cycle in which the port-clock enable `port_tick` is high. It is 16 bits wide by default and wraps modulo 2^16.

A client uses the block in two steps. It first issues an immediate write, which sets the pin and returns the counter value at which that happened. It then computes future counter values from that reference and issues timed writes. Each timed write pairs a pin value with the count at which the value must appear. This places every edge an exact number of port clocks after the previous one. Only one timed write can wait at a time, and `wr_ready` stays low while it waits. With an internally clocked port running from a 100 MHz reference, each count is 10 ns, so a gap of 8 counts is 80 ns.

Top module: `tsp_out_port`

## Requirements
- R1: After reset, the counter is 0, `pin_out` is 0, `wr_ready` is 1 and `ts_valid` is 0. An immediate write accepted before any tick returns `ts_time` = 0.
- R2: The counter increments by one at each clock edge where `port_tick` is 1. It holds its value when `port_tick` is 0. It wraps from 0xFFFF to 0.
- R3: A write is accepted at a clock edge where `wr_valid` and `wr_ready` are both 1. If it is immediate (`wr_timed` = 0), `pin_out` takes `wr_value` at that edge. In the next cycle `ts_valid` is 1 for exactly one cycle, and `ts_time` holds the counter value present in the accept cycle.
- R4: A timed write (`wr_timed` = 1) is held pending. `pin_out` takes its value at the first clock edge at which `port_tick` is 1 and the counter equals `wr_time`. In the following cycle `ts_valid` pulses for one cycle with `ts_time` = `wr_time`.
- R5: `wr_ready` is 0 from the cycle after a timed write is accepted until the cycle in which it fires, and it is 1 again in the cycle after. A write offered while `wr_ready` is 0 is not taken and does not change `pin_out`.
- R6: `pin_out` changes only at an edge given by R3 or R4. `ts_valid` is 1 only in the cycle after such an edge.
- R7: With `port_tick` held at 1, a chain of timed writes at cumulative offsets (for example +20, +60, +47, +33 from an immediate write) gives pin edges exactly that many clock cycles apart.
- R8: A timed write whose `wr_time` equals the counter value in its accept cycle fires only after the counter wraps round, 65536 ticks after acceptance. The pin does not change before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_tick | input | 1 | Port-clock enable; one counter step per high cycle |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Block can accept a write (no timed write pending) |
| wr_value | input | 1 | Pin value to write |
| wr_time | input | 16 | Counter value at which a timed write fires |
| wr_timed | input | 1 | 1 = timed write, 0 = immediate write |
| ts_valid | output | 1 | One-cycle pulse: a write has just taken effect |
| ts_time | output | 16 | Counter value at which that write took effect |
| pin_out | output | 1 | The driven pin |

## Verification
The bench aims at four cases, each with the failure it would expose:
- **Immediate-write timestamp.** A design that returns the counter value after the increment would shift every scheduled edge by one count.
- **Spacing of a chained edge sequence.** A design that compares against the counter a cycle late would show up as edges one clock off.
- **Request offered while a timed write is pending.** A design with a leaky ready would let a pending value be overwritten or the pin glitch.
- **Timed write aimed at the current count.** A design that fired at once, or mishandled the wrap, would change the pin 65536 ticks too early or never.

Random enable gating checks that matches happen only on tick cycles.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    // Kind of write request, as carried on wr_timed
    typedef enum logic {
        KIND_NOW = 1'b0,
        KIND_AT  = 1'b1
    } wr_kind_e;

endpackage

// File: rtl/tsp_counter.sv
// Free-running port counter: one step per port-clock enable, natural wrap.
module tsp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tsp_match.sv
// Equality compare of the port counter with a pending target time.
module tsp_match #(
    parameter int W = 16
) (
    input  logic         armed_i,
    input  logic         tick_i,
    input  logic [W-1:0] now_i,
    input  logic [W-1:0] at_i,
    output logic         hit_o
);

    assign hit_o = armed_i && tick_i && (now_i == at_i);

endmodule

// File: rtl/tsp_out_port.sv
// Single-pin output port with immediate and timestamp-scheduled writes.
module tsp_out_port
    import tsp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_tick,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic             wr_value,
    input  logic [CNT_W-1:0] wr_time,
    input  logic             wr_timed,
    output logic             ts_valid,
    output logic [CNT_W-1:0] ts_time,
    output logic             pin_out
);

    typedef struct packed {
        logic             pend;   // a timed write is waiting
        logic             pval;   // its pin value
        logic [CNT_W-1:0] ptime;  // its target count
        logic             pin;    // driven pin level
        logic             tsv;    // timestamp pulse
        logic [CNT_W-1:0] tst;    // timestamp value
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0] cnt_w;
    logic             fire_w;
    logic             pend_w;
    logic [CNT_W-1:0] ptime_w;
    logic             accept_w;

    assign pend_w  = st_q.pend;
    assign ptime_w = st_q.ptime;

    tsp_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (port_tick),
        .cnt_o  (cnt_w)
    );

    tsp_match #(.W(CNT_W)) u_match (
        .armed_i (pend_w),
        .tick_i  (port_tick),
        .now_i   (cnt_w),
        .at_i    (ptime_w),
        .hit_o   (fire_w)
    );

    assign accept_w = wr_valid && !pend_w;

    always_comb begin
        st_d     = st_q;
        st_d.tsv = 1'b0;
        if (fire_w) begin
            st_d.pin  = st_q.pval;
            st_d.pend = 1'b0;
            st_d.tsv  = 1'b1;
            st_d.tst  = st_q.ptime;
        end else if (accept_w) begin
            if (wr_kind_e'(wr_timed) == KIND_AT) begin
                st_d.pend  = 1'b1;
                st_d.pval  = wr_value;
                st_d.ptime = wr_time;
            end else begin
                st_d.pin = wr_value;
                st_d.tsv = 1'b1;
                st_d.tst = cnt_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ready = !pend_w;
    assign ts_valid = st_q.tsv;
    assign ts_time  = st_q.tst;
    assign pin_out  = st_q.pin;

endmodule

// File: rtl/tsp_out_port_chk.sv
// Property checker attached to tsp_out_port.
module tsp_out_port_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_tick,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             wr_value,
    input logic             wr_timed,
    input logic             ts_valid,
    input logic [CNT_W-1:0] ts_time,
    input logic             pin_out,
    input logic [CNT_W-1:0] cnt,
    input logic             pend,
    input logic [CNT_W-1:0] ptime
);

    logic [CNT_W-1:0] cnt_inc;
    logic             take_now;
    logic             take_at;
    logic             due;

    assign cnt_inc  = cnt + 1'b1;
    assign take_now = wr_valid && wr_ready && !wr_timed;
    assign take_at  = wr_valid && wr_ready && wr_timed;
    assign due      = pend && port_tick && (cnt == ptime);

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        port_tick |=> (cnt == $past(cnt_inc)));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !port_tick |=> $stable(cnt));

    a_r3_now_stamp: assert property (@(posedge clk) disable iff (!rst_n)
        take_now |=> (ts_valid && ts_time == $past(cnt) && pin_out == $past(wr_value)));

    a_r4_fire_stamp: assert property (@(posedge clk) disable iff (!rst_n)
        due |=> (ts_valid && ts_time == $past(ptime) && wr_ready));

    a_r5_busy_after_timed: assert property (@(posedge clk) disable iff (!rst_n)
        take_at |=> !wr_ready);

    a_r6_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_now && !due) |=> $stable(pin_out));

    a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_now && !due) |=> !ts_valid);

endmodule

bind tsp_out_port tsp_out_port_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_tick (port_tick),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_value  (wr_value),
    .wr_timed  (wr_timed),
    .ts_valid  (ts_valid),
    .ts_time   (ts_time),
    .pin_out   (pin_out),
    .cnt       (cnt_w),
    .pend      (pend_w),
    .ptime     (ptime_w)
);

// File: tb/tsp_out_port_bench.sv
module tsp_out_port_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         port_tick;
    logic         wr_valid;
    logic         wr_ready;
    logic         wr_value;
    logic [W-1:0] wr_time;
    logic         wr_timed;
    logic         ts_valid;
    logic [W-1:0] ts_time;
    logic         pin_out;

    always #10 clk = ~clk;   // 50 MHz

    tsp_out_port #(.CNT_W(W)) u_tsp_out_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_tick (port_tick),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_value  (wr_value),
        .wr_time   (wr_time),
        .wr_timed  (wr_timed),
        .ts_valid  (ts_valid),
        .ts_time   (ts_time),
        .pin_out   (pin_out)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // Reference model state, built from the requirements
    logic [W-1:0] m_cnt;
    logic         m_pend;
    logic         m_pval;
    logic [W-1:0] m_ptime;
    logic         m_pin;
    logic         m_tsv;
    logic [W-1:0] m_tst;
    logic         last_acc;
    logic [W-1:0] acc_cnt;

    function automatic void check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    function automatic void model_reset();
        m_cnt = '0; m_pend = 1'b0; m_pval = 1'b0; m_ptime = '0;
        m_pin = 1'b0; m_tsv = 1'b0; m_tst = '0; last_acc = 1'b0;
    endfunction

    function automatic void model_step();
        logic acc, fire;
        acc  = wr_valid && !m_pend;
        fire = m_pend && port_tick && (m_cnt == m_ptime);
        last_acc = acc;
        m_tsv = 1'b0;
        if (acc) acc_cnt = m_cnt;
        if (fire) begin
            m_pin = m_pval; m_pend = 1'b0; m_tsv = 1'b1; m_tst = m_ptime;
        end else if (acc) begin
            if (wr_timed) begin
                m_pend = 1'b1; m_pval = wr_value; m_ptime = wr_time;
            end else begin
                m_pin = wr_value; m_tsv = 1'b1; m_tst = m_cnt;
            end
        end
        if (port_tick) m_cnt = m_cnt + 1'b1;
    endfunction

    // One clock: model updates at the edge, outputs are compared at the next falling edge
    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cyc++;
        check("R6", "pin_out", 32'(pin_out), 32'(m_pin));
        check("R5", "wr_ready", 32'(wr_ready), 32'(!m_pend));
        check("R3", "ts_valid", 32'(ts_valid), 32'(m_tsv));
        if (m_tsv) check("R4", "ts_time", 32'(ts_time), 32'(m_tst));
    endtask

    task automatic do_write(logic v, logic [W-1:0] t, logic timed);
        wr_valid = 1'b1; wr_value = v; wr_time = t; wr_timed = timed;
        for (int i = 0; i < 8; i++) begin
            step();
            if (last_acc) break;
        end
        wr_valid = 1'b0;
    endtask

    task automatic wait_pulse(int limit, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!ts_valid && n < limit);
    endtask

    initial begin
        int n;
        int last_edge;
        logic [W-1:0] t;
        logic [W-1:0] a_cnt;
        logic v;
        int offs[4];
        void'($urandom(32'd4242));
        rst_n = 1'b0; port_tick = 1'b0; wr_valid = 1'b0;
        wr_value = 1'b0; wr_time = '0; wr_timed = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();

        // R1: reset state
        check("R1", "pin_out", 32'(pin_out), 32'd0);
        check("R1", "wr_ready", 32'(wr_ready), 32'd1);
        check("R1", "ts_valid", 32'(ts_valid), 32'd0);
        do_write(1'b0, '0, 1'b0);
        check("R1", "ts_time after reset", 32'(ts_time), 32'd0);

        // R2: only tick cycles advance the counter
        for (int i = 0; i < 10; i++) begin
            port_tick = (i % 2 == 0);
            step();
        end
        port_tick = 1'b0;
        do_write(1'b1, '0, 1'b0);
        check("R2", "gated count", 32'(ts_time), 32'd5);
        check("R3", "pin after immediate", 32'(pin_out), 32'd1);

        // R3: immediate write returns the pre-increment count
        port_tick = 1'b1;
        repeat (37) step();
        do_write(1'b0, '0, 1'b0);
        check("R3", "stamp", 32'(ts_time), 32'd42);
        step();
        check("R3", "pulse one cycle", 32'(ts_valid), 32'd0);

        // R7: chained timed edges at +20 +60 +47 +33
        do_write(1'b0, '0, 1'b0);
        t = acc_cnt;
        last_edge = cyc;
        offs = '{20, 60, 47, 33};
        v = 1'b1;
        foreach (offs[k]) begin
            t = t + W'(offs[k]);
            do_write(v, t, 1'b1);
            wait_pulse(200, n);
            check("R7", "edge spacing", 32'(cyc - last_edge), 32'(offs[k]));
            check("R4", "fire stamp", 32'(ts_time), 32'(t));
            check("R4", "fire value", 32'(pin_out), 32'(v));
            last_edge = cyc;
            v = ~v;
        end

        // R5: requests while pending are ignored
        do_write(1'b1, m_cnt + W'(12), 1'b1);
        wr_valid = 1'b1; wr_timed = 1'b0; wr_value = 1'b1;
        repeat (4) begin
            step();
            check("R5", "ready while pending", 32'(wr_ready), 32'd0);
            check("R5", "pin untouched", 32'(pin_out), 32'd0);
        end
        wr_valid = 1'b0;
        wait_pulse(50, n);
        check("R5", "ready after fire", 32'(wr_ready), 32'd1);
        check("R4", "pending value lands", 32'(pin_out), 32'd1);

        // R8: target equal to current count waits a full wrap
        a_cnt = m_cnt;
        do_write(1'b0, a_cnt, 1'b1);
        wait_pulse(70000, n);
        check("R8", "wrap wait", 32'(n), 32'd65536);
        check("R8", "wrap stamp", 32'(ts_time), 32'(a_cnt));
        check("R2", "pin after wrap", 32'(pin_out), 32'd0);

        // Random phase with gated ticks
        for (int i = 0; i < 3000; i++) begin
            port_tick = ($urandom % 4) != 0;
            wr_valid = 1'b0;
            if (!m_pend && ($urandom % 3) == 0) begin
                wr_valid = 1'b1;
                wr_timed = $urandom % 2;
                wr_value = $urandom % 2;
                wr_time  = m_cnt + W'(1 + $urandom % 30);
            end else if (m_pend && ($urandom % 8) == 0) begin
                wr_valid = 1'b1;              // R5: must be ignored
                wr_timed = $urandom % 2;
                wr_value = $urandom % 2;
                wr_time  = W'($urandom);
            end
            step();
        end
        wr_valid = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule